// File: doc/BRIEF.md
# Line and Field Sync Timebase

This block is the line and field timebase of a digital video encoder running from a 27 MHz sample clock. It steps a sample counter across each line and a line counter across each frame. From these counters it decodes horizontal sync, vertical sync, horizontal and vertical blanking, a field parity flag, and a one-cycle strobe that marks the first sample of every line. One pin selects a 525-line frame of 1716 clocks per line, or a 625-line frame of 1728 clocks per line.

In master mode the block is the system's sync source. It drives its sync outputs and raises an output-enable for the sync pads, and any external sync pins are ignored. In slave mode the sync outputs and the enable are held low. The counters then follow external active-low sync inputs. A horizontal falling edge starts a new line, and a vertical falling edge restarts the frame at line 1. The asynchronous active-low reset does not clear the counters to zero. It parks them at line 64, sample 0, which is the start of horizontal sync inside horizontal blanking. The block has no data stream, so every pin is a plain level or strobe, with no valid/ready handshake and no back-pressure.

Top module: `video_timebase`

## Requirements
- R1: While `rst_ni` is low the sample count is 0, the line number is 64, `field_o` is 0, `line_start_o` is 0 and `hblank_o` is 1. In master mode `hs_o` and `sync_oe_o` are also 1.
- R2: With `std625_i`=1 in master mode, `line_start_o` pulses once every 1728 clocks. The sample count runs 0 to 1727 and wraps to 0.
- R3: With `std625_i`=1, `hs_o` is high for samples 0 to 125 (126 clocks) and `hblank_o` is high for samples 0 to 287 (288 clocks). `hs_o` is never high outside horizontal blanking.
- R4: With `std625_i`=0, the line lasts 1716 clocks, `hs_o` lasts 127 clocks and `hblank_o` lasts 276 clocks.
- R5: Lines are numbered from 1 and advance by one at each line start. The number wraps to 1 after line 625 (or 525). `field_o` is 0 on lines 1 to 312 (1 to 262) and 1 on lines 313 to 625 (263 to 525). It toggles only on entry to line 1 or to the second-field start line.
- R6: `vs_o` is high on the first three lines of each field (1–3 and 313–315, or 1–3 and 263–265). `vblank_o` is high on the first 22 lines of each field for 625 lines and the first 19 lines for 525 lines.
- R7: In slave mode (`master_i`=0), `hs_o`, `vs_o` and `sync_oe_o` are 0. A 1-to-0 transition of `ext_hs_ni` sets the sample count to 0 on the next edge and advances the line.
- R8: In slave mode a 1-to-0 transition of `ext_vs_ni` sets the line number to 1 and `field_o` to 0 on the next edge. The sample count keeps running.
- R9: In master mode, transitions on `ext_hs_ni` and `ext_vs_ni` have no effect on the sample count or the line number.
- R10: Reset acts asynchronously: lowering `rst_ni` between clock edges puts the counters in the R1 state at once.
- R11: `line_start_o` is high only in a cycle where the sample count is 0, and only in the cycle right after a line advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = drive sync, 0 = follow external sync |
| std625_i | input | 1 | 1 = 625-line/1728-clock, 0 = 525-line/1716-clock |
| ext_hs_ni | input | 1 | External horizontal sync, active low (slave mode) |
| ext_vs_ni | input | 1 | External vertical sync, active low (slave mode) |
| hs_o | output | 1 | Horizontal sync, active high, master mode only |
| vs_o | output | 1 | Vertical sync, active high, master mode only |
| sync_oe_o | output | 1 | Output enable for sync pads |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| field_o | output | 1 | 0 = first field, 1 = second field |
| line_start_o | output | 1 | One-cycle strobe at sample 0 of a line |
| pix_o | output | PIX_W (11) | Sample count within the line |
| line_o | output | LINE_W (10) | Line number within the frame, from 1 |

## Verification
Assertions check on every cycle that the sample counter either steps by one or wraps exactly at the line end, and that an external edge in slave mode reloads the counters. They also check that the sync pins and their enable stay low outside master mode, that the line-start strobe coincides with sample 0, and that the field flag changes only on line 1 or the second-field start line. Only the bench scenarios can show the absolute numbers: the 1728- and 1716-clock periods, the 126/127-clock sync and 288/276-clock blanking widths, and the exact lines on which vertical sync and blanking begin and end. The same holds for the line-64 reset landing and the sequence of line and field values across a full frame, which the bench walks through by stepping lines with fast external sync pulses.

// File: rtl/vtb_pkg.sv
package vtb_pkg;

  typedef enum logic {
    STD_525 = 1'b0,
    STD_625 = 1'b1
  } vstd_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vtb_hcount.sv
module vtb_hcount #(
  parameter int unsigned PIX_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] line_len_i,
  input  logic             reload_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             adv_o
);

  logic [PIX_W-1:0] pix_q;
  logic             at_end;

  // >= so that a standard change mid-line still wraps
  assign at_end = (pix_q >= line_len_i - PIX_W'(1));
  assign adv_o  = at_end | reload_i;
  assign pix_o  = pix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q <= '0;
    end else if (reload_i || at_end) begin
      pix_q <= '0;
    end else begin
      pix_q <= pix_q + PIX_W'(1);
    end
  end

  p_wrap_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload_i && pix_q == line_len_i - PIX_W'(1)) |=> (pix_q == '0));

  p_step_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload_i && pix_q < line_len_i - PIX_W'(1)) |=> (pix_q == $past(pix_q) + PIX_W'(1)));

  p_reload_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (pix_q == '0));

endmodule

// File: rtl/vtb_vcount.sv
module vtb_vcount #(
  parameter int unsigned LINE_W     = 10,
  parameter int unsigned RESET_LINE = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] frame_lines_i,
  input  logic [LINE_W-1:0] field2_line_i,
  input  logic              adv_i,
  input  logic              vreload_i,
  output logic [LINE_W-1:0] line_o,
  output logic              field_o,
  output logic              line_start_o
);

  logic [LINE_W-1:0] line_q, line_inc;
  logic              field_q, start_q;

  assign line_inc     = line_q + LINE_W'(1);
  assign line_o       = line_q;
  assign field_o      = field_q;
  assign line_start_o = start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= LINE_W'(RESET_LINE);
      field_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= adv_i;
      if (vreload_i) begin
        line_q  <= LINE_W'(1);
        field_q <= 1'b0;
      end else if (adv_i) begin
        if (line_q >= frame_lines_i) begin
          line_q  <= LINE_W'(1);
          field_q <= ~field_q;
        end else begin
          line_q <= line_inc;
          if (line_inc == field2_line_i) field_q <= ~field_q;
        end
      end
    end
  end

  p_line_nonzero_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_q != '0);

  p_field_edge_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(field_q) |-> (line_q == LINE_W'(1) || line_q == field2_line_i));

  p_vreload_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    vreload_i |=> (line_q == LINE_W'(1) && !field_q));

endmodule

// File: rtl/vtb_decode.sv
module vtb_decode #(
  parameter int unsigned PIX_W    = 11,
  parameter int unsigned LINE_W   = 10,
  parameter int unsigned VS_LINES = 3
) (
  input  logic              master_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [PIX_W-1:0]  hs_len_i,
  input  logic [PIX_W-1:0]  hbl_len_i,
  input  logic [LINE_W-1:0] vbl_lines_i,
  input  logic [LINE_W-1:0] field2_line_i,
  output logic              hs_o,
  output logic              vs_o,
  output logic              oe_o,
  output logic              hblank_o,
  output logic              vblank_o
);

  logic in_vs1, in_vs2, in_vb1, in_vb2, hs_raw;

  always_comb begin
    hs_raw   = (pix_i < hs_len_i);
    hblank_o = (pix_i < hbl_len_i);
    in_vs1   = (line_i < LINE_W'(1 + VS_LINES));
    in_vs2   = (line_i >= field2_line_i) && (line_i < field2_line_i + LINE_W'(VS_LINES));
    in_vb1   = (line_i < LINE_W'(1) + vbl_lines_i);
    in_vb2   = (line_i >= field2_line_i) && (line_i < field2_line_i + vbl_lines_i);
    vblank_o = in_vb1 | in_vb2;
    hs_o     = master_i & hs_raw;
    vs_o     = master_i & (in_vs1 | in_vs2);
    oe_o     = master_i;
  end

endmodule

// File: rtl/video_timebase.sv
module video_timebase
  import vtb_pkg::*;
#(
  parameter int unsigned LEN_525    = 1716,
  parameter int unsigned LEN_625    = 1728,
  parameter int unsigned LINES_525  = 525,
  parameter int unsigned LINES_625  = 625,
  parameter int unsigned HSW_525    = 127,
  parameter int unsigned HSW_625    = 126,
  parameter int unsigned HBL_525    = 276,
  parameter int unsigned HBL_625    = 288,
  parameter int unsigned VBL_525    = 19,
  parameter int unsigned VBL_625    = 22,
  parameter int unsigned VS_LINES   = 3,
  parameter int unsigned RESET_LINE = 64,
  parameter int unsigned PIX_W      = $clog2(max_u(LEN_525, LEN_625)),
  parameter int unsigned LINE_W     = $clog2(max_u(LINES_525, LINES_625) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              std625_i,
  input  logic              ext_hs_ni,
  input  logic              ext_vs_ni,
  output logic              hs_o,
  output logic              vs_o,
  output logic              sync_oe_o,
  output logic              hblank_o,
  output logic              vblank_o,
  output logic              field_o,
  output logic              line_start_o,
  output logic [PIX_W-1:0]  pix_o,
  output logic [LINE_W-1:0] line_o
);

  localparam int unsigned F2_525 = LINES_525 / 2 + 1;
  localparam int unsigned F2_625 = LINES_625 / 2 + 1;
  localparam int unsigned N_EXT  = 2;

  vstd_e             std_sel;
  logic [PIX_W-1:0]  line_len, hs_len, hbl_len;
  logic [LINE_W-1:0] frame_lines, field2_line, vbl_lines;
  logic [N_EXT-1:0]  ext_n, ext_fall;
  logic              h_adv;

  assign std_sel = vstd_e'(std625_i);

  always_comb begin
    unique case (std_sel)
      STD_625: begin
        line_len    = PIX_W'(LEN_625);
        hs_len      = PIX_W'(HSW_625);
        hbl_len     = PIX_W'(HBL_625);
        frame_lines = LINE_W'(LINES_625);
        field2_line = LINE_W'(F2_625);
        vbl_lines   = LINE_W'(VBL_625);
      end
      default: begin
        line_len    = PIX_W'(LEN_525);
        hs_len      = PIX_W'(HSW_525);
        hbl_len     = PIX_W'(HBL_525);
        frame_lines = LINE_W'(LINES_525);
        field2_line = LINE_W'(F2_525);
        vbl_lines   = LINE_W'(VBL_525);
      end
    endcase
  end

  // index 0: horizontal, index 1: vertical
  assign ext_n = {ext_vs_ni, ext_hs_ni};

  for (genvar g = 0; g < N_EXT; g++) begin : g_edge
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b1;
      else         prev_q <= ext_n[g];
    end
    // external edges only count when following
    assign ext_fall[g] = prev_q & ~ext_n[g] & ~master_i;
  end

  vtb_hcount #(.PIX_W(PIX_W)) u_hcount (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_len_i (line_len),
    .reload_i   (ext_fall[0]),
    .pix_o      (pix_o),
    .adv_o      (h_adv)
  );

  vtb_vcount #(.LINE_W(LINE_W), .RESET_LINE(RESET_LINE)) u_vcount (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_lines_i (frame_lines),
    .field2_line_i (field2_line),
    .adv_i         (h_adv),
    .vreload_i     (ext_fall[1]),
    .line_o        (line_o),
    .field_o       (field_o),
    .line_start_o  (line_start_o)
  );

  vtb_decode #(.PIX_W(PIX_W), .LINE_W(LINE_W), .VS_LINES(VS_LINES)) u_decode (
    .master_i      (master_i),
    .pix_i         (pix_o),
    .line_i        (line_o),
    .hs_len_i      (hs_len),
    .hbl_len_i     (hbl_len),
    .vbl_lines_i   (vbl_lines),
    .field2_line_i (field2_line),
    .hs_o          (hs_o),
    .vs_o          (vs_o),
    .oe_o          (sync_oe_o),
    .hblank_o      (hblank_o),
    .vblank_o      (vblank_o)
  );

  p_slave_quiet_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (!hs_o && !vs_o && !sync_oe_o));

  p_hs_in_blank_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_o |-> hblank_o);

  p_vs_in_blank_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_o |-> vblank_o);

  p_start_at_zero_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |-> (pix_o == '0));

  p_master_ignores_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && pix_o == PIX_W'(1)) |=> (pix_o == PIX_W'(2)));

endmodule

// File: tb/test_video_timebase.sv
module test_video_timebase;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master = 1'b1;
  logic        std625 = 1'b1;
  logic        ext_hs_n = 1'b1;
  logic        ext_vs_n = 1'b1;
  logic        hs, vs, oe, hbl, vbl, field, lstart;
  logic [10:0] pix;
  logic [9:0]  line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cur_line = 0;

  typedef struct { int ln; int fld; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  video_timebase i_video_timebase (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .std625_i(std625),
    .ext_hs_ni(ext_hs_n), .ext_vs_ni(ext_vs_n),
    .hs_o(hs), .vs_o(vs), .sync_oe_o(oe), .hblank_o(hbl), .vblank_o(vbl),
    .field_o(field), .line_start_o(lstart), .pix_o(pix), .line_o(line)
  );

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int exp_field(input int l, input int n);
    return (l >= n / 2 + 1 && l <= n) ? 1 : 0;
  endfunction

  // scoreboard monitor: every line start is compared against the next queued item
  always @(negedge clk) begin
    if (rst_n && lstart && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk("R5 line number", int'(line), e.ln);
      chk("R5 field flag", int'(field), e.fld);
    end
  end

  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!lstart);
  endtask

  task automatic pulse_hs(output int pix_after);
    ext_hs_n = 1'b0;
    @(negedge clk);
    pix_after = int'(pix);
    ext_hs_n = 1'b1;
    @(negedge clk);
  endtask

  // driver: queue expected line/field, then step by external sync
  task automatic step_to(input int target, input int n);
    int p;
    while (cur_line != target) begin
      int nxt;
      nxt = (cur_line >= n) ? 1 : cur_line + 1;
      exp_q.push_back('{nxt, exp_field(nxt, n)});
      pulse_hs(p);
      cur_line = nxt;
    end
  endtask

  task automatic mcheck(input string req, input int evs, input int evbl);
    master = 1'b1;
    #1;
    chk({req, " vs"}, int'(vs), evs);
    chk({req, " vblank"}, int'(vbl), evbl);
    master = 1'b0;
  endtask

  task automatic widths(input string req, input int ehs, input int ehb, input int elen);
    int h, b, n;
    h = 0;
    b = 0;
    while (hbl) begin
      if (hs) h++;
      b++;
      @(negedge clk);
    end
    chk({req, " hsync width"}, h, ehs);
    chk({req, " hblank width"}, b, ehb);
    measure(n);
    chk({req, " line period"}, b + n, elen);
  endtask

  initial begin
    int n, p;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pix", int'(pix), 0);
    chk("R1 line", int'(line), 64);
    chk("R1 field", int'(field), 0);
    chk("R1 line_start", int'(lstart), 0);
    chk("R1 hblank", int'(hbl), 1);
    chk("R1 hsync", int'(hs), 1);
    chk("R1 oe", int'(oe), 1);

    // R2/R3: master, 625 lines
    exp_q.push_back('{65, 0});
    exp_q.push_back('{66, 0});
    rst_n = 1'b1;
    measure(n);
    chk("R2 first line period", n, 1728);
    widths("R3", 126, 288, 1728);
    @(negedge clk);
    chk("R11 strobe one cycle", int'(lstart), 0);
    chk("R5 scoreboard drained", exp_q.size(), 0);

    // R9: external edges ignored in master mode
    p = int'(pix);
    ext_hs_n = 1'b0;
    ext_vs_n = 1'b0;
    @(negedge clk);
    chk("R9 pix unaffected", int'(pix), p + 1);
    chk("R9 line unaffected", int'(line), 66);
    ext_hs_n = 1'b1;
    ext_vs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 line still", int'(line), 66);

    // R7: slave gating
    master = 1'b0;
    #1;
    chk("R7 hs gated", int'(hs), 0);
    chk("R7 oe low", int'(oe), 0);
    chk("R7 vs gated", int'(vs), 0);
    @(negedge clk);

    // R8: vertical reload
    p = int'(pix);
    ext_vs_n = 1'b0;
    @(negedge clk);
    chk("R8 line reload", int'(line), 1);
    chk("R8 field reset", int'(field), 0);
    chk("R8 pix keeps running", int'(pix), p + 1);
    ext_vs_n = 1'b1;
    @(negedge clk);
    cur_line = 1;

    // R7: horizontal reload
    exp_q.push_back('{2, 0});
    pulse_hs(p);
    cur_line = 2;
    chk("R7 hs reload pix", p, 0);

    // R5: full frame walk, R6 vertical sync / blanking lines
    step_to(625, 625);
    step_to(1, 625);
    chk("R5 wrap line", int'(line), 1);
    chk("R5 wrap field", int'(field), 0);
    mcheck("R6 line1", 1, 1);
    step_to(3, 625);   mcheck("R6 line3", 1, 1);
    step_to(4, 625);   mcheck("R6 line4", 0, 1);
    step_to(22, 625);  mcheck("R6 line22", 0, 1);
    step_to(23, 625);  mcheck("R6 line23", 0, 0);
    step_to(312, 625); mcheck("R6 line312", 0, 0);
    step_to(313, 625); mcheck("R6 line313", 1, 1);
    chk("R5 field2 start", int'(field), 1);
    step_to(315, 625); mcheck("R6 line315", 1, 1);
    step_to(316, 625); mcheck("R6 line316", 0, 1);
    step_to(334, 625); mcheck("R6 line334", 0, 1);
    step_to(335, 625); mcheck("R6 line335", 0, 0);
    chk("R5 scoreboard drained 625", exp_q.size(), 0);

    // R10: asynchronous reset between edges
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R10 async pix", int'(pix), 0);
    chk("R10 async line", int'(line), 64);
    chk("R10 async field", int'(field), 0);

    // R4: 525 lines
    std625 = 1'b0;
    master = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    measure(n);
    chk("R4 first line period", n, 1716);
    widths("R4", 127, 276, 1716);

    // R5/R6 for 525 lines
    master = 1'b0;
    @(negedge clk);
    ext_vs_n = 1'b0;
    @(negedge clk);
    ext_vs_n = 1'b1;
    @(negedge clk);
    cur_line = 1;
    chk("R8 line reload 525", int'(line), 1);
    step_to(262, 525); chk("R5 field 262", int'(field), 0);
    step_to(263, 525); chk("R5 field 263", int'(field), 1);
    mcheck("R6 line263", 1, 1);
    step_to(281, 525); mcheck("R6 line281", 0, 1);
    step_to(282, 525); mcheck("R6 line282", 0, 0);
    step_to(525, 525);
    step_to(1, 525);
    chk("R5 wrap 525 field", int'(field), 0);
    chk("R5 scoreboard drained 525", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule